// File: doc/BRIEF.md
# Synchronous Serial Shift Engine

This block is a minimal serial port for a processor subsystem. Software moves each bit through an 8-bit shift register that it reads and writes directly. The core supplies only the bit-level timing. It runs as a three-wire synchronous port (clock, data out, data in) or as a two-wire open-drain port (clock and a shared data line), and it can act as clock master or as slave. Addressing, acknowledge handling and byte framing are left to software.

The shift clock comes from one of three places:
- a software toggle strobe,
- a timer-compare strobe,
- the external clock pin, sampled on the rising edge or on the falling edge.

A 4-bit counter counts every clock edge, both rising and falling. When it wraps, it raises the transfer-done flag, so 16 edges move one byte. Software can preload the counter to make a transfer shorter. The outgoing bit passes through a latch that is open only while the clock sits at its idle level, so the output moves on the edge opposite the sampling edge.

In two-wire mode, a start detector watches for the data line falling while the clock line is high. While the start flag or the done flag is set, the core holds the clock line low.

Top module: `sync_serial_core`

## Requirements
- R1: After reset, the data register, the counter, both flags, the control register, every output enable and both interrupt outputs are 0.
- R2: Register map: address 0 is the data register (read/write); address 1 is status; address 2 is control; address 3 is the strobe register. Status holds the start flag at bit 7, the done flag at bit 6 and the counter at bits 3:0. A write to address 0 replaces the shift register, and a write to address 1 loads bits 3:0 into the counter. Control holds the wire mode at bits 1:0 (01 three-wire, 10 two-wire), the clock source at bits 3:2 (00 software, 01 timer, 10 pin with rising-edge sampling, 11 pin with falling-edge sampling), the start interrupt enable at bit 4 and the done interrupt enable at bit 5.
- R3: On each sampling edge, the register shifts left and takes the synchronized data-in pin into bit 0. The sampling edge is the rising edge for sources 00, 01 and 10, and the falling edge for source 11. There is no holding buffer, so each shift overwrites the previous contents.
- R4: The counter advances by one on every clock edge of the selected source. When it goes from 15 to 0, it sets the done flag.
- R5: pin_do_o carries the register MSB through a latch that is open only while the clock is at its idle level (low, or high for source 11). The output therefore changes only after the edge opposite the sampling edge.
- R6: In three-wire mode, pin_do_oe is 1 and pin_sda_oe is 0. In two-wire mode, pin_do_oe is 0 and pin_sda_oe is the inverse of the latched bit, so the line is pulled low for a 0.
- R7: In two-wire mode, the data pin falling while the clock pin is high sets the start flag. In any other mode, this pin pattern has no effect.
- R8: In two-wire mode, pin_sck_oe is 1 and pin_sck_o is 0 while the start flag or the done flag is set.
- R9: Writing 1 to status bit 7 or bit 6 clears that flag. irq_start equals start flag AND its enable; irq_done equals done flag AND its enable.
- R10: With source 00, writing 1 to strobe bit 0 toggles the internal clock. That toggle is one counted edge, and it drives pin_sck_o in three-wire mode, where pin_sck_oe is 1 for internal sources.
- R11: Only the selected internal source makes edges. tmr_strobe has no effect with source 00, and the software toggle has no effect with source 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tmr_strobe | input | 1 | Timer-compare clock strobe |
| pin_sck_i | input | 1 | Clock pin level |
| pin_sck_o | output | 1 | Clock pin drive value |
| pin_sck_oe | output | 1 | Clock pin drive enable |
| pin_di_i | input | 1 | Data-in / two-wire data pin level |
| pin_do_o | output | 1 | Latched outgoing bit |
| pin_do_oe | output | 1 | Three-wire data-out enable |
| pin_sda_oe | output | 1 | Two-wire data pull-low enable |
| irq_start | output | 1 | Start-condition interrupt |
| irq_done | output | 1 | Transfer-done interrupt |

## Verification
The in-line assertions watch four things on every cycle:
- each counted edge advances the counter by one, and a wrap is followed by the done flag;
- a shift moves the register left by one place with the sampled bit entering;
- the outgoing bit stays stable while the latch is closed;
- the two-wire clock hold stays in force while a flag is set, start flags appear only in two-wire mode, and the two data enables never overlap.

Whole-byte results can only come from the bench scenarios. These cover the exact byte after 16 edges from each clock source, a short transfer after a counter preload, the bit order seen at the data pin, and the source-selection cases where a strobe must be ignored.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_THREE = 2'b01,
    WM_TWO   = 2'b10,
    WM_RSVD  = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_PIN_RISE = 2'b10,
    CS_PIN_FALL = 2'b11
  } csrc_e;

  typedef struct packed {
    logic   done_ie;
    logic   start_ie;
    csrc_e  src;
    wmode_e wmode;
  } ctrl_t;

  localparam int CTRL_W = 6;

  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_STATUS = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_STROBE = 2'd3;

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[CHAIN_W-W-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/ssc_edge_counter.sv
module ssc_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
endmodule

// File: rtl/ssc_start_detect.sv
module ssc_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sda,
  input  logic scl,
  output logic start_set
);
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev_q <= 1'b0;
    else        sda_prev_q <= sda;
  end

  always_comb start_set = enable & sda_prev_q & ~sda & scl;
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              din,
  input  logic              latch_open,
  output logic [DATA_W-1:0] data,
  output logic              out_bit
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              out_q, out_d;

  always_comb begin
    data_d = data_q;
    if (load)       data_d = load_val;
    else if (shift) data_d = {data_q[DATA_W-2:0], din};
    out_d = latch_open ? data_q[DATA_W-1] : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      out_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      out_q  <= out_d;
    end
  end

  assign data    = data_q;
  assign out_bit = out_q;

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (data_q == {$past(data_q[DATA_W-2:0]), $past(din)})); // R3
endmodule

// File: rtl/sync_serial_core.sv
module sync_serial_core
  import ssc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tmr_strobe,
  input  logic              pin_sck_i,
  output logic              pin_sck_o,
  output logic              pin_sck_oe,
  input  logic              pin_di_i,
  output logic              pin_do_o,
  output logic              pin_do_oe,
  output logic              pin_sda_oe,
  output logic              irq_start,
  output logic              irq_done
);
  localparam int STAT_PAD = DATA_W - 2 - CNT_W;
  localparam int CTRL_PAD = DATA_W - CTRL_W;
  localparam int BIT_ST   = DATA_W - 1;
  localparam int BIT_DN   = DATA_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // pin synchronizers
  logic sck_s, di_s;
  ssc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d({pin_sck_i, pin_di_i}), .q({sck_s, di_s})
  );

  // bus decode
  logic wr_data, wr_stat, wr_ctrl, wr_strb;
  always_comb begin
    wr_data = bus_we & (bus_addr == A_DATA);
    wr_stat = bus_we & (bus_addr == A_STATUS);
    wr_ctrl = bus_we & (bus_addr == A_CTRL);
    wr_strb = bus_we & (bus_addr == A_STROBE);
  end

  // state
  ctrl_t ctrl_q, ctrl_d;
  logic  sck_out_q, sck_out_d;
  logic  sck_prev_q;
  logic  start_q, start_d;
  logic  done_q, done_d;

  // clock event generation
  logic int_src, tog_evt, edge_evt, new_lvl, cur_lvl, samp_pol;
  logic sample_evt, latch_open;

  always_comb begin
    int_src  = (ctrl_q.src == CS_SOFT) || (ctrl_q.src == CS_TIMER);
    tog_evt  = ((ctrl_q.src == CS_SOFT)  && wr_strb && bus_wdata[0]) ||
               ((ctrl_q.src == CS_TIMER) && tmr_strobe);
    samp_pol = (ctrl_q.src != CS_PIN_FALL);
    if (int_src) begin
      edge_evt = tog_evt;
      new_lvl  = ~sck_out_q;
      cur_lvl  = sck_out_q;
    end else begin
      edge_evt = (sck_s != sck_prev_q);
      new_lvl  = sck_s;
      cur_lvl  = sck_s;
    end
    sample_evt = edge_evt && (new_lvl == samp_pol);
    latch_open = (cur_lvl != samp_pol);
    sck_out_d  = tog_evt ? ~sck_out_q : sck_out_q;
  end

  // counter and shifter
  logic [CNT_W-1:0]  cnt;
  logic              cnt_wrap;
  logic [DATA_W-1:0] data;
  logic              out_bit;

  ssc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .load(wr_stat), .load_val(bus_wdata[CNT_W-1:0]),
    .inc(edge_evt), .cnt(cnt), .wrap(cnt_wrap)
  );

  ssc_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_ni), .load(wr_data), .load_val(bus_wdata),
    .shift(sample_evt), .din(di_s), .latch_open(latch_open),
    .data(data), .out_bit(out_bit)
  );

  // start detector
  logic start_set;
  ssc_start_detect u_start (
    .clk(clk), .rst_n(rst_ni), .enable(ctrl_q.wmode == WM_TWO),
    .sda(di_s), .scl(sck_s), .start_set(start_set)
  );

  // flags and control next state
  always_comb begin
    ctrl_d  = wr_ctrl ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    start_d = (start_q & ~(wr_stat & bus_wdata[BIT_ST])) | start_set;
    done_d  = (done_q  & ~(wr_stat & bus_wdata[BIT_DN])) | cnt_wrap;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      sck_out_q  <= 1'b0;
      sck_prev_q <= 1'b0;
      start_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      sck_out_q  <= sck_out_d;
      sck_prev_q <= sck_s;
      start_q    <= start_d;
      done_q     <= done_d;
    end
  end

  // pins
  logic hold;
  always_comb begin
    hold       = (ctrl_q.wmode == WM_TWO) && (start_q || done_q);
    pin_do_o   = out_bit;
    pin_sck_o  = 1'b0;
    pin_sck_oe = 1'b0;
    pin_do_oe  = 1'b0;
    pin_sda_oe = 1'b0;
    case (ctrl_q.wmode)
      WM_THREE: begin
        pin_sck_o  = sck_out_q;
        pin_sck_oe = int_src;
        pin_do_oe  = 1'b1;
      end
      WM_TWO: begin
        pin_sck_oe = hold || (int_src && !sck_out_q);
        pin_sda_oe = ~out_bit;
      end
      default: ;
    endcase
    irq_start = start_q & ctrl_q.start_ie;
    irq_done  = done_q  & ctrl_q.done_ie;
  end

  // read mux
  always_comb begin
    case (bus_addr)
      A_DATA:   bus_rdata = data;
      A_STATUS: bus_rdata = {start_q, done_q, {STAT_PAD{1'b0}}, cnt};
      A_CTRL:   bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      default:  bus_rdata = '0;
    endcase
  end

  AST_WRAP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_wrap |=> done_q); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q.wmode == WM_THREE && !latch_open && !wr_ctrl) |=> $stable(pin_do_o)); // R5
  AST_DATA_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(pin_do_oe && pin_sda_oe)); // R6
  AST_START_TWO_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(start_q) |-> ($past(ctrl_q.wmode) == WM_TWO)); // R7
  AST_SCL_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q.wmode == WM_TWO && (start_q || done_q)) |-> (pin_sck_oe && !pin_sck_o)); // R8
  AST_IRQ_DONE_SRC: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_done |-> done_q); // R9
endmodule

// File: tb/sync_serial_core_bench.sv
module sync_serial_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tmr_strobe = 1'b0;
  logic       pin_sck_i = 1'b0;
  logic       pin_sck_o, pin_sck_oe;
  logic       pin_di_i = 1'b0;
  logic       pin_do_o, pin_do_oe, pin_sda_oe, irq_start, irq_done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  sync_serial_core u_sync_serial_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_strobe(tmr_strobe),
    .pin_sck_i(pin_sck_i), .pin_sck_o(pin_sck_o), .pin_sck_oe(pin_sck_oe),
    .pin_di_i(pin_di_i), .pin_do_o(pin_do_o), .pin_do_oe(pin_do_oe),
    .pin_sda_oe(pin_sda_oe), .irq_start(irq_start), .irq_done(irq_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tmr_pulse();
    @(negedge clk); tmr_strobe = 1'b1;
    @(negedge clk); tmr_strobe = 1'b0;
  endtask

  function automatic logic [7:0] stat_exp(input logic st, input logic dn, input logic [3:0] c);
    return {st, dn, 2'b00, c};
  endfunction

  function automatic logic [7:0] partial_shift(input logic [7:0] d, input logic [7:0] e, input int nb);
    logic [7:0] r = d;
    for (int i = 0; i < nb; i++) r = {r[6:0], e[7-i]};
    return r;
  endfunction

  // master byte transfer with software toggles (three-wire, source 00)
  task automatic soft_byte(input logic [7:0] d, input logic [7:0] e);
    int bad_do = 0;
    logic [7:0] v;
    wr(2'd0, d);
    for (int k = 0; k < 8; k++) begin
      pin_di_i = e[7-k];
      wait_cyc(4);
      if (pin_do_o !== d[7-k]) bad_do++;
      wr(2'd3, 8'h01);
      wait_cyc(2);
      wr(2'd3, 8'h01);
      wait_cyc(3);
    end
    check("R5 do bit order (soft)", bad_do, 0);
    rd(2'd0, v); check("R3 soft byte", v, e);
    rd(2'd1, v); check("R4 soft wrap", v, stat_exp(1'b0, 1'b1, 4'd0));
    wr(2'd1, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, d, e;
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));

    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    rd(2'd0, v); check("R1 data", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 ctrl", v, 8'h00);
    check("R1 enables", {pin_sck_oe, pin_do_oe, pin_sda_oe, irq_start, irq_done}, 5'b0);

    // R2 register access
    wr(2'd0, 8'hA5); rd(2'd0, v); check("R2 data rw", v, 8'hA5);
    wr(2'd1, 8'h07); rd(2'd1, v); check("R2 count preload", v, stat_exp(0, 0, 4'd7));
    wr(2'd2, 8'h21); rd(2'd2, v); check("R2 ctrl rw", v, 8'h21);
    wr(2'd1, 8'h00);

    // R10 software toggle drives clock pin
    wr(2'd2, 8'h01);
    wait_cyc(1);
    check("R6 three-wire enables", {pin_do_oe, pin_sda_oe}, 2'b10);
    check("R10 sck oe master", pin_sck_oe, 1'b1);
    wr(2'd3, 8'h01); wait_cyc(1);
    check("R10 sck toggled high", pin_sck_o, 1'b1);
    rd(2'd1, v); check("R10 toggle counted", v, stat_exp(0, 0, 4'd1));
    wr(2'd3, 8'h01); wait_cyc(1);
    check("R10 sck toggled low", pin_sck_o, 1'b0);
    wr(2'd1, 8'h00);

    // directed + random software transfers
    soft_byte(8'h80, 8'h01);
    soft_byte(8'h00, 8'hFF);
    for (int i = 0; i < 10; i++) begin
      d = 8'($urandom());
      e = 8'($urandom());
      soft_byte(d, e);
    end

    // R11 timer ignored under software source
    tmr_pulse(); tmr_pulse(); tmr_pulse();
    rd(2'd1, v); check("R11 timer ignored (soft)", v, stat_exp(0, 0, 4'd0));

    // timer source with done interrupt
    wr(2'd2, 8'h25);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 15; i++) tmr_pulse();
    rd(2'd1, v); check("R4 timer count 15", v, stat_exp(0, 0, 4'd15));
    check("R9 no irq yet", irq_done, 1'b0);
    wr(2'd3, 8'h01);
    rd(2'd1, v); check("R11 soft ignored (timer)", v, stat_exp(0, 0, 4'd15));
    tmr_pulse(); wait_cyc(1);
    check("R9 irq_done on wrap", irq_done, 1'b1);
    wr(2'd1, 8'h40); wait_cyc(1);
    check("R9 irq_done cleared", irq_done, 1'b0);

    // external clock, rising sampling, slave three-wire
    pin_sck_i = 1'b0;
    wr(2'd2, 8'h09);
    wait_cyc(4);
    check("R6 slave sck oe", pin_sck_oe, 1'b0);
    d = 8'h3C; e = 8'($urandom());
    wr(2'd0, d);
    begin
      int bad_do = 0;
      for (int k = 0; k < 8; k++) begin
        pin_di_i = e[7-k];
        wait_cyc(4);
        if (pin_do_o !== d[7-k]) bad_do++;
        pin_sck_i = 1'b1; wait_cyc(4);
        pin_sck_i = 1'b0; wait_cyc(4);
      end
      check("R5 do bit order (pin rise)", bad_do, 0);
    end
    rd(2'd0, v); check("R3 pin rise byte", v, e);
    rd(2'd1, v); check("R4 pin rise wrap", v, stat_exp(0, 1, 4'd0));
    wr(2'd1, 8'h40);

    // external falling sampling with preload 8 (4 bits)
    pin_sck_i = 1'b1; wait_cyc(4);
    wr(2'd2, 8'h0D);
    d = 8'($urandom()); e = 8'($urandom());
    wr(2'd0, d);
    wr(2'd1, 8'h08);
    for (int k = 0; k < 4; k++) begin
      pin_di_i = e[7-k];
      wait_cyc(4);
      pin_sck_i = 1'b0; wait_cyc(4);
      pin_sck_i = 1'b1; wait_cyc(4);
    end
    rd(2'd0, v); check("R3 falling short transfer", v, partial_shift(d, e, 4));
    rd(2'd1, v); check("R4 preload wrap", v, stat_exp(0, 1, 4'd0));
    wr(2'd1, 8'h40);

    // R7 pattern ignored in three-wire
    pin_sck_i = 1'b0; wait_cyc(4);
    wr(2'd2, 8'h09);
    pin_sck_i = 1'b1; pin_di_i = 1'b1; wait_cyc(5);
    pin_di_i = 1'b0; wait_cyc(5);
    rd(2'd1, v); check("R7 no start in three-wire", v[7], 1'b0);
    pin_sck_i = 1'b0; wait_cyc(4);
    pin_di_i = 1'b1; wait_cyc(4);
    pin_sck_i = 1'b1; wait_cyc(4);
    wr(2'd1, 8'h40);

    // two-wire start detect and hold
    wr(2'd2, 8'h1A);
    wait_cyc(4);
    check("R6 two-wire do oe", pin_do_oe, 1'b0);
    pin_di_i = 1'b0; wait_cyc(5);
    rd(2'd1, v); check("R7 start flag", v[7], 1'b1);
    check("R9 irq_start", irq_start, 1'b1);
    check("R8 hold after start", {pin_sck_oe, pin_sck_o}, 2'b10);
    wr(2'd1, 8'h80); wait_cyc(1);
    check("R9 start cleared", {irq_start, pin_sck_oe}, 2'b00);
    pin_sck_i = 1'b0; wait_cyc(4);
    wr(2'd0, 8'h00); wait_cyc(3);
    check("R6 sda pulled for 0", pin_sda_oe, 1'b1);
    wr(2'd0, 8'h80); wait_cyc(3);
    check("R6 sda released for 1", pin_sda_oe, 1'b0);
    wr(2'd1, 8'h4F);
    pin_di_i = 1'b1; wait_cyc(4);
    pin_sck_i = 1'b1; wait_cyc(5);
    rd(2'd1, v); check("R4 two-wire wrap", v[6], 1'b1);
    check("R8 hold after done", {pin_sck_oe, pin_sck_o}, 2'b10);
    wr(2'd1, 8'h40); wait_cyc(1);
    check("R8 hold released", pin_sck_oe, 1'b0);

    finish_run();
  end
endmodule